// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a receive MAC and places every incoming frame into a circular set of host buffers. Software sets up two arrays in memory: one of descriptors (a buffer pointer word and then a control word whose low field gives the buffer size less one) and one of status entries (an information word and then a hash/CRC word). Software also supplies the base of each array, the ring size less one, and a consume index that it advances after it has processed an entry.

For each frame the block fetches the descriptor at the current produce index and streams the frame words into that buffer. It then writes the status entry with the stored length less one and the error flags, and only after that does it advance the produce index. If the slot just before the consume index would be used, the ring is full: the frame is taken off the stream and thrown away, and a one-cycle overrun pulse is raised. Frames longer than their buffer are cut to the buffer size and flagged.

The frame stream is 32 bits wide. Bytes are packed in order, and a final-beat field gives how many bytes of the last word are valid. The memory side is a single word port. A read returns its data in the cycle after the request.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the produce index is 0, the empty flag is 1, the full flag and overrun are 0, the stream ready is 0, and no memory write has occurred.
- R2: For the slot at produce index i, the buffer pointer is read from descriptor base + 8*i and the control word from descriptor base + 8*i + 4. Only control bits [10:0] (buffer size minus one, in bytes) are used; bit 31 has no effect on storage.
- R3: Frame word k is written to buffer pointer + 4*k, in arrival order.
- R4: The status information word is written to status base + 8*i with bits [10:0] equal to the stored byte count minus one, and the word at status base + 8*i + 4 is written with zero.
- R5: After a stored frame the produce index steps by one, and it wraps from the ring-size-minus-one value to 0. It never exceeds that value.
- R6: The empty flag is 1 exactly when the produce index equals the consume index.
- R7: The ring is full when the index after the produce index equals the consume index. A frame that starts while the ring is full is accepted from the stream without any memory write and without moving the produce index, and overrun is high for exactly one cycle.
- R8: A frame longer than the buffer stores only the bytes that fit. The length field then holds the buffer size minus one, and status bits 27 (truncated) and 28 (error summary) are set. No word at or beyond the buffer end is written. A frame that fits exactly is not flagged.
- R9: If the error input is high on any beat of a frame, status bits 23 (MAC error) and 28 (error summary) are set for that frame.
- R10: The produce index changes only in the cycle after the last status word write, so a new index never exposes an incomplete status entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descBase | input | 32 | Byte address of the descriptor array |
| statBase | input | 32 | Byte address of the status array (8-byte aligned) |
| ringLast | input | IDX_W | Ring size minus one |
| consumeIdx | input | IDX_W | Software consume index |
| rxValid | input | 1 | Stream beat valid |
| rxReady | output | 1 | Stream beat accepted when high with rxValid |
| rxData | input | 32 | Stream word, bytes in order |
| rxLast | input | 1 | Final beat of frame |
| rxLastBytes | input | 2 | Valid bytes in final beat minus one |
| rxErr | input | 1 | MAC-reported error for the current frame |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Write (1) or read (0) |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read |
| produceIdx | output | IDX_W | Produce index |
| ringEmpty | output | 1 | Ring empty flag |
| ringFull | output | 1 | Ring full flag |
| overrun | output | 1 | One-cycle pulse per dropped frame |

## Verification
The bench builds the block with a 3-bit index field and runs a ring of four slots (last index 3). The wrap therefore comes from the size register and not from the index field's own rollover. The four descriptors have buffer sizes of 64, 128, 40 and 256 bytes and their buffers sit in reverse address order, so an indexing slip puts data in the wrong place. The sizes bring truncation, the exact-fit boundary, a full ring with a dropped frame and the wrap back to slot 0 into a short run.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef struct packed {
    logic rdPtr;   // read buffer pointer word
    logic rdCtl;   // read control word
    logic capPtr;  // capture pointer from read data
    logic capCtl;  // capture size, clear frame state
    logic take;    // accepting stream beats into buffer
    logic wrInfo;  // write status information word
    logic wrHash;  // write hash word, advance index
    logic drop;    // frame dropped on full ring
  } rxr_strobe_t;

  localparam int BIT_MAC_ERR = 23;
  localparam int BIT_TRUNC   = 27;
  localparam int BIT_ERR_SUM = 28;
endpackage

// File: rtl/rxr_control.sv
module rxr_control
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        ringFull,
  output logic        rxReady,
  output rxr_strobe_t st
);
  typedef enum logic [2:0] {
    S_IDLE, S_RDPTR, S_RDCTL, S_CAPCTL, S_DATA, S_DROP, S_INFO, S_HASH
  } state_t;

  state_t state, stateNext;

  always_comb begin
    st        = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (rxValid) begin
        if (ringFull) begin
          st.drop   = 1'b1;
          stateNext = S_DROP;
        end else begin
          stateNext = S_RDPTR;
        end
      end
      S_RDPTR: begin
        st.rdPtr  = 1'b1;
        stateNext = S_RDCTL;
      end
      S_RDCTL: begin
        st.rdCtl  = 1'b1;
        st.capPtr = 1'b1;
        stateNext = S_CAPCTL;
      end
      S_CAPCTL: begin
        st.capCtl = 1'b1;
        stateNext = S_DATA;
      end
      S_DATA: begin
        st.take = 1'b1;
        if (rxValid && rxLast) stateNext = S_INFO;
      end
      S_DROP: if (rxValid && rxLast) stateNext = S_IDLE;
      S_INFO: begin
        st.wrInfo = 1'b1;
        stateNext = S_HASH;
      end
      S_HASH: begin
        st.wrHash = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign rxReady = (state == S_DATA) || (state == S_DROP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxr_strobe_t      st,
  input  logic             rxValid,
  input  logic [31:0]      rxData,
  input  logic             rxLast,
  input  logic [1:0]       rxLastBytes,
  input  logic             rxErr,
  input  logic [31:0]      descBase,
  input  logic [31:0]      statBase,
  input  logic [IDX_W-1:0] ringLast,
  input  logic [IDX_W-1:0] consumeIdx,
  input  logic [31:0]      memRdata,
  output logic             memEn,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  output logic [IDX_W-1:0] prodIdx,
  output logic             ringEmpty,
  output logic             ringFull,
  output logic             overrun
);
  localparam int CNT_W = LEN_W + 2;

  logic [IDX_W-1:0] nextIdx;
  logic [31:0]      bufPtr, descAddr, statAddr, infoWord;
  logic [LEN_W-1:0] sizeM1;
  logic [CNT_W-1:0] byteTot, wordOff, bufBytes, beatBytes, sumBytes, lenM1;
  logic             truncFlag, macErrFlag, inBuf, beatFire;

  assign nextIdx   = (prodIdx == ringLast) ? '0 : prodIdx + 1'b1;
  assign ringFull  = (nextIdx == consumeIdx);
  assign ringEmpty = (prodIdx == consumeIdx);

  assign descAddr  = descBase + (32'(prodIdx) << 3);
  assign statAddr  = statBase + (32'(prodIdx) << 3);

  assign bufBytes  = CNT_W'(sizeM1) + 1'b1;
  assign inBuf     = wordOff < bufBytes;
  assign beatFire  = st.take && rxValid;
  assign beatBytes = rxLast ? CNT_W'(rxLastBytes) + 1'b1 : CNT_W'(4);
  assign sumBytes  = byteTot + beatBytes;
  assign lenM1     = byteTot - 1'b1;

  always_comb begin
    infoWord              = '0;
    infoWord[LEN_W-1:0]   = lenM1[LEN_W-1:0];
    infoWord[BIT_MAC_ERR] = macErrFlag;
    infoWord[BIT_TRUNC]   = truncFlag;
    infoWord[BIT_ERR_SUM] = macErrFlag | truncFlag;
  end

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memAddr  = descAddr;
    memWdata = '0;
    if (st.rdPtr) begin
      memEn = 1'b1;
    end else if (st.rdCtl) begin
      memEn   = 1'b1;
      memAddr = descAddr + 32'd4;
    end else if (beatFire && inBuf) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = bufPtr + 32'(wordOff);
      memWdata = rxData;
    end else if (st.wrInfo) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = statAddr;
      memWdata = infoWord;
    end else if (st.wrHash) begin
      memEn   = 1'b1;
      memWe   = 1'b1;
      memAddr = statAddr + 32'd4;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodIdx    <= '0;
      bufPtr     <= '0;
      sizeM1     <= '0;
      byteTot    <= '0;
      wordOff    <= '0;
      truncFlag  <= 1'b0;
      macErrFlag <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      overrun <= st.drop;
      if (st.capPtr) bufPtr <= memRdata;
      if (st.capCtl) begin
        sizeM1     <= memRdata[LEN_W-1:0];
        byteTot    <= '0;
        wordOff    <= '0;
        truncFlag  <= 1'b0;
        macErrFlag <= 1'b0;
      end
      if (beatFire) begin
        if (inBuf) wordOff <= wordOff + CNT_W'(4);
        if (!truncFlag) begin
          if (sumBytes > bufBytes) begin
            truncFlag <= 1'b1;
            byteTot   <= bufBytes;
          end else begin
            byteTot <= sumBytes;
          end
        end
        if (rxErr) macErrFlag <= 1'b1;
      end
      if (st.wrHash) prodIdx <= nextIdx;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      descBase,
  input  logic [31:0]      statBase,
  input  logic [IDX_W-1:0] ringLast,
  input  logic [IDX_W-1:0] consumeIdx,
  input  logic             rxValid,
  output logic             rxReady,
  input  logic [31:0]      rxData,
  input  logic             rxLast,
  input  logic [1:0]       rxLastBytes,
  input  logic             rxErr,
  output logic             memEn,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic [IDX_W-1:0] produceIdx,
  output logic             ringEmpty,
  output logic             ringFull,
  output logic             overrun
);
  rxr_strobe_t st;

  rxr_control uCtl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast),
    .ringFull(ringFull), .rxReady(rxReady), .st(st)
  );

  rxr_datapath #(.IDX_W(IDX_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .rxLastBytes(rxLastBytes), .rxErr(rxErr),
    .descBase(descBase), .statBase(statBase), .ringLast(ringLast),
    .consumeIdx(consumeIdx), .memRdata(memRdata), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .prodIdx(produceIdx), .ringEmpty(ringEmpty), .ringFull(ringFull),
    .overrun(overrun)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rxReady,
  input logic             rxLast,
  input logic             memEn,
  input logic             memWe,
  input logic [IDX_W-1:0] produceIdx,
  input logic [IDX_W-1:0] ringLast,
  input logic             overrun
);
  logic dropReg, dropNow;

  assign dropNow = overrun || dropReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dropReg <= 1'b0;
    else       dropReg <= dropNow && !(rxValid && rxReady && rxLast);
  end

  // R5: index stays within ring
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rstN)
    produceIdx <= ringLast);

  // R5: each move is a single step with wrap
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(produceIdx) |->
      produceIdx == (($past(produceIdx) == $past(ringLast)) ? '0 : $past(produceIdx) + 1'b1));

  // R10: index moves only right after a status write
  a_r10_index_after_status: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(produceIdx) |-> $past(memEn && memWe));

  // R7: no memory write while a dropped frame drains
  a_r7_drop_no_write: assert property (@(posedge clk) disable iff (!rstN)
    dropNow |-> !(memEn && memWe));

  // R7: overrun is a single-cycle pulse
  a_r7_overrun_pulse: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> !overrun);
endmodule

bind rx_ring_writer rxr_checker #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxReady(rxReady),
  .rxLast(rxLast), .memEn(memEn), .memWe(memWe), .produceIdx(produceIdx),
  .ringLast(ringLast), .overrun(overrun)
);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int IW = 3;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic [31:0]   descBase, statBase;
  logic [IW-1:0] ringLast, consumeIdx;
  logic          rxValid, rxReady, rxLast, rxErr;
  logic [31:0]   rxData;
  logic [1:0]    rxLastBytes;
  logic          memEn, memWe;
  logic [31:0]   memAddr, memWdata, memRdata;
  logic [IW-1:0] produceIdx;
  logic          ringEmpty, ringFull, overrun;

  rx_ring_writer #(.IDX_W(IW), .LEN_W(11)) u0 (
    .clk(clk), .rstN(rstN), .descBase(descBase), .statBase(statBase),
    .ringLast(ringLast), .consumeIdx(consumeIdx), .rxValid(rxValid),
    .rxReady(rxReady), .rxData(rxData), .rxLast(rxLast),
    .rxLastBytes(rxLastBytes), .rxErr(rxErr), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .produceIdx(produceIdx), .ringEmpty(ringEmpty), .ringFull(ringFull),
    .overrun(overrun)
  );

  logic [31:0] mem [0:4095];
  int wrCount = 0;
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        mem[memAddr[13:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end else begin
        memRdata <= mem[memAddr[13:2]];
      end
    end
  end

  typedef struct {
    int          slot;
    logic [31:0] info;
    int          words;
    int          seed;
    string       req;
  } exp_t;

  exp_t q[$];
  int nChk = 0, nBad = 0, ovrCnt = 0, expProd = 0;
  int sizes[4] = '{64, 128, 40, 256};
  bit done = 1'b0;

  function automatic int bufOf(int s);
    return 32'h400 + (3 - s) * 32'h100;
  endfunction

  function automatic logic [31:0] wordOf(int seed, int k);
    return {8'(seed), 8'h5A, 16'(k)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // driver: pushes expectations, then streams the frame
  task automatic sendFrame(int n, bit err, int seed, string req);
    int nb, s, nextP, stored;
    exp_t e;
    nb = (n + 3) / 4;
    s = expProd;
    nextP = (expProd == 3) ? 0 : expProd + 1;
    if (nextP != int'(consumeIdx)) begin
      stored = (n > sizes[s]) ? sizes[s] : n;
      for (int k = 0; k < 64; k++) mem[(bufOf(s) >> 2) + k] = SENT;
      e.slot = s;
      e.info = 32'(stored - 1);
      if (err) e.info[23] = 1'b1;
      if (n > sizes[s]) e.info[27] = 1'b1;
      if (err || n > sizes[s]) e.info[28] = 1'b1;
      e.words = (stored + 3) / 4;
      e.seed = seed;
      e.req = req;
      q.push_back(e);
      expProd = nextP;
    end
    for (int k = 0; k < nb; k++) begin
      rxValid = 1'b1;
      rxData = wordOf(seed, k);
      rxLast = (k == nb - 1);
      rxLastBytes = 2'((n - 1) % 4);
      rxErr = err && (k == 0);
      while (!rxReady) @(negedge clk);
      @(negedge clk);
    end
    rxValid = 1'b0;
    rxLast = 1'b0;
    rxErr = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops an expectation each time the produce index moves
  logic [IW-1:0] lastProd = '0;
  always @(negedge clk) begin
    if (!rstN) begin
      lastProd = '0;
    end else begin
      if (overrun) ovrCnt++;
      if (produceIdx != lastProd) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected index move", 32'(produceIdx), 32'(lastProd));
        end else begin
          exp_t e;
          int sa, ba;
          e = q.pop_front();
          sa = (32'h100 + 8 * e.slot) >> 2;
          ba = bufOf(e.slot) >> 2;
          chk(int'(lastProd) == e.slot, "R5 slot order", 32'(lastProd), 32'(e.slot));
          chk(produceIdx == ((lastProd == 3) ? IW'(0) : lastProd + 1'b1),
              "R5 step/wrap", 32'(produceIdx), 32'((lastProd == 3) ? 0 : lastProd + 1));
          chk(mem[sa] == e.info, e.req, mem[sa], e.info);
          chk(mem[sa + 1] == 32'h0, "R4 hash word", mem[sa + 1], 32'h0);
          chk(mem[ba] == wordOf(e.seed, 0), "R2 data at pointer", mem[ba], wordOf(e.seed, 0));
          for (int k = 1; k < e.words; k++)
            chk(mem[ba + k] == wordOf(e.seed, k), "R3 data word", mem[ba + k], wordOf(e.seed, k));
          if (e.words < 64)
            chk(mem[ba + e.words] == SENT, "R8 past end untouched", mem[ba + e.words], SENT);
        end
        lastProd = produceIdx;
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      report();
    end
  end

  initial begin
    int w, o;
    rstN = 1'b0;
    rxValid = 1'b0; rxLast = 1'b0; rxErr = 1'b0; rxData = '0; rxLastBytes = '0;
    descBase = 32'h0; statBase = 32'h100; ringLast = 3'd3; consumeIdx = 3'd0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int s = 0; s < 4; s++) begin
      mem[2 * s] = bufOf(s);
      mem[2 * s + 1] = 32'(sizes[s] - 1);
    end
    mem[3] = mem[3] | 32'h8000_0000;  // R2: interrupt bit on slot 1
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(produceIdx == 0, "R1 produce", 32'(produceIdx), 32'h0);
    chk(ringEmpty == 1'b1, "R1 empty", 32'(ringEmpty), 32'h1);
    chk(ringFull == 1'b0, "R1 full", 32'(ringFull), 32'h0);
    chk(overrun == 1'b0, "R1 overrun", 32'(overrun), 32'h0);
    chk(rxReady == 1'b0, "R1 ready", 32'(rxReady), 32'h0);
    chk(wrCount == 0, "R1 writes", 32'(wrCount), 32'h0);

    sendFrame(20, 1'b0, 1, "R4 status plain");
    drain();
    chk(ringEmpty == 1'b0, "R6 not empty", 32'(ringEmpty), 32'h0);

    sendFrame(61, 1'b1, 2, "R9 mac error");
    drain();

    sendFrame(100, 1'b0, 3, "R8 truncated");
    drain();
    chk(ringFull == 1'b1, "R7 full", 32'(ringFull), 32'h1);

    w = wrCount;
    o = ovrCnt;
    sendFrame(12, 1'b0, 4, "R7 drop");
    repeat (4) @(negedge clk);
    chk(wrCount == w, "R7 no write on drop", 32'(wrCount), 32'(w));
    chk(ovrCnt == o + 1, "R7 overrun pulse", 32'(ovrCnt), 32'(o + 1));
    chk(produceIdx == 3, "R7 index held", 32'(produceIdx), 32'h3);

    consumeIdx = 3'd2;
    @(negedge clk);
    chk(ringFull == 1'b0, "R7 not full", 32'(ringFull), 32'h0);

    sendFrame(256, 1'b0, 5, "R8 exact fit");
    drain();
    chk(produceIdx == 0, "R5 wrap to 0", 32'(produceIdx), 32'h0);

    consumeIdx = 3'd0;
    @(negedge clk);
    chk(ringEmpty == 1'b1, "R6 empty", 32'(ringEmpty), 32'h1);

    sendFrame(1, 1'b0, 6, "R4 one byte");
    drain();
    sendFrame(8, 1'b0, 7, "R4 back to back a");
    sendFrame(40, 1'b1, 8, "R9 back to back b");
    drain();
    chk(produceIdx == 3, "R5 final index", 32'(produceIdx), 32'h3);
    chk(q.size() == 0, "R10 all retired", 32'(q.size()), 32'h0);

    done = 1'b1;
    report();
  end
endmodule